// File: doc/BRIEF.md
# Pseudo-static RAM access sequencer

This block connects a simple host port that uses a request/acknowledge handshake to an 8-bit pseudo-static RAM with a 19-bit address. For each host request it runs one single-byte read or write cycle on the memory pins. Between accesses it keeps the array alive by issuing periodic automatic refresh strobes. The memory has one control pin with two roles. While the chip is selected it enables the read drivers. While the chip is deselected, each low pulse on it starts one refresh.

A free-running interval timer raises a sticky "refresh owed" flag once every `REF_CYC` clocks. A central state machine decides what happens next. A refresh that falls due during an access waits until that access has finished. A refresh that is already owed wins over a host request that is waiting in the idle state. After every access and after every refresh, the state machine holds all strobes high for a recovery window. This guarantees that the dual-role pin is high before its next falling edge, so the refresh logic in the memory can re-arm.

States: `ST_IDLE` (arbitrate), `ST_SETUP` (address driven, chip still deselected), `ST_ACTIVE` (chip selected for `ACC_CYC` clocks), `ST_ACK` (chip released, acknowledge and read data valid), `ST_RFSH` (refresh strobe low for `PULSE_CYC` clocks), `ST_RECOV` (all strobes high for `RECOV_CYC` clocks). The transitions are:
- IDLE→RFSH when refresh is owed.
- IDLE→SETUP when a request is present and no refresh is owed.
- SETUP→ACTIVE always.
- ACTIVE→ACK when the access timer expires.
- ACK→RECOV always.
- RFSH→RECOV when the pulse timer expires.
- RECOV→IDLE when the recovery timer expires.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is asserted, and in idle afterwards, `psr_sel_n`, `psr_wr_n` and `psr_oe_ref_n` are 1, and `psr_dq_oe` and `host_ack` are 0.
- R2: An accepted request drives its full address on `psr_addr` for one clock with `psr_sel_n` still 1. `psr_sel_n` is then 0 for exactly `ACC_CYC` clocks, and `psr_addr` stays unchanged while it is 0. The address passes through unaltered: bits 0–10 are the row and bits 11–18 are the column.
- R3: In a read cycle (`host_wr`=0), `psr_oe_ref_n`=0 and `psr_wr_n`=1 while selected. In a write cycle (`host_wr`=1), `psr_wr_n`=0, `psr_oe_ref_n`=1, `psr_dq_oe`=1 and `psr_dq_out` equals the host byte while selected. `psr_dq_oe` is 0 at all other times.
- R4: `host_ack` is 1 for exactly one clock, namely the clock right after the chip is deselected. For a read, `host_rdata` in that clock equals `psr_dq_in` as sampled in the last selected clock.
- R5: A refresh is a low pulse on `psr_oe_ref_n`, lasting exactly `PULSE_CYC` clocks, with `psr_sel_n`=1 throughout. The pulse is shorter than `SELF_CYC` clocks, so it is never taken as a self-refresh request.
- R6: Before every falling edge of `psr_oe_ref_n`, the pin has been high for at least `RECOV_CYC` clocks. The chip is selected only when the pin was high in the previous clock.
- R7: A refresh becomes owed on every `REF_CYC`-th clock after reset. Each owed refresh produces exactly one pulse.
- R8: A refresh that becomes owed during an access is issued right after that access's recovery window. When a refresh is owed and a request is also waiting in idle, the refresh pulse goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Access request, held until acknowledge |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | One-clock acknowledge |
| host_rdata | output | 8 | Read byte, valid with acknowledge |
| psr_sel_n | output | 1 | Chip select, active low |
| psr_wr_n | output | 1 | Write strobe, active low |
| psr_oe_ref_n | output | 1 | Output enable while selected; refresh strobe while deselected |
| psr_addr | output | 19 | Memory address |
| psr_dq_out | output | 8 | Data toward memory |
| psr_dq_oe | output | 1 | Drive enable for `psr_dq_out` |
| psr_dq_in | input | 8 | Data from memory |

## Verification
Writes and reads go to the all-zero address, the all-ones address, an address with only row bits set, and an address with only column bits set. A slice fault in `psr_addr` or a swapped data path would show up there. Back-to-back requests show whether recovery is enforced between accesses. One request is timed to land in the clock when a refresh is already owed, which separates correct priority from request-first arbitration. Another is timed so that the refresh falls due mid-access, which shows whether the refresh is deferred or cuts into the access. Long idle stretches count refresh pulses against the interval, and every clock is compared with a behavioural model.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_ACK,
        ST_RFSH,
        ST_RECOV
    } psr_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/psram_ref_timer.sv
module psram_ref_timer #(
    parameter int REF_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic due
);
    localparam int CW = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(REF_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            due   <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (wrap)
                due <= 1'b1;
            else if (clr)
                due <= 1'b0;
        end
    end
endmodule

// File: rtl/psram_delay_cnt.sv
module psram_delay_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int REF_CYC   = 1560,
    parameter int ACC_CYC   = 7,
    parameter int PULSE_CYC = 4,
    parameter int RECOV_CYC = 3,
    parameter int SELF_CYC  = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              psr_sel_n,
    output logic              psr_wr_n,
    output logic              psr_oe_ref_n,
    output logic [ADDR_W-1:0] psr_addr,
    output logic [DATA_W-1:0] psr_dq_out,
    output logic              psr_dq_oe,
    input  logic [DATA_W-1:0] psr_dq_in
);
    localparam int MAXD = max3(ACC_CYC, PULSE_CYC, RECOV_CYC);
    localparam int DW   = $clog2(MAXD + 1);

    psr_state_e        state_q, state_d;
    logic              ref_due, ref_clr;
    logic              dly_load, dly_done;
    logic [DW-1:0]     dly_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              wr_q;
    logic              accept;

    psram_ref_timer #(.REF_CYC(REF_CYC)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ref_clr),
        .due   (ref_due)
    );

    psram_delay_cnt #(.W(DW)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .done     (dly_done)
    );

    // next-state and arbitration
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_due)
                    state_d = ST_RFSH;
                else if (host_req)
                    state_d = ST_SETUP;
            end
            ST_SETUP:  state_d = ST_ACTIVE;
            ST_ACTIVE: if (dly_done) state_d = ST_ACK;
            ST_ACK:    state_d = ST_RECOV;
            ST_RFSH:   if (dly_done) state_d = ST_RECOV;
            ST_RECOV:  if (dly_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_d)
            ST_ACTIVE: dly_val = DW'(ACC_CYC - 1);
            ST_RFSH:   dly_val = DW'(PULSE_CYC - 1);
            ST_RECOV:  dly_val = DW'(RECOV_CYC - 1);
            default:   dly_val = '0;
        endcase
    end

    assign dly_load = (state_d != state_q);
    assign ref_clr  = (state_q == ST_IDLE) && ref_due;
    assign accept   = (state_q == ST_IDLE) && !ref_due && host_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // request capture and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= host_addr;
                wdata_q <= host_wdata;
                wr_q    <= host_wr;
            end
            if (state_q == ST_ACTIVE && dly_done && !wr_q)
                rdata_q <= psr_dq_in;
        end
    end

    // outputs decoded from state
    always_comb begin
        psr_sel_n    = 1'b1;
        psr_wr_n     = 1'b1;
        psr_oe_ref_n = 1'b1;
        psr_dq_oe    = 1'b0;
        host_ack     = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                psr_sel_n    = 1'b0;
                psr_wr_n     = !wr_q;
                psr_oe_ref_n = wr_q;
                psr_dq_oe    = wr_q;
            end
            ST_ACK:  host_ack     = 1'b1;
            ST_RFSH: psr_oe_ref_n = 1'b0;
            default: ;
        endcase
    end

    assign psr_addr   = addr_q;
    assign psr_dq_out = wdata_q;
    assign host_rdata = rdata_q;
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
    parameter int ADDR_W    = 19,
    parameter int RECOV_CYC = 3,
    parameter int PULSE_CYC = 4,
    parameter int SELF_CYC  = 800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic              psr_sel_n,
    input logic              psr_wr_n,
    input logic              psr_oe_ref_n,
    input logic              psr_dq_oe,
    input logic [ADDR_W-1:0] psr_addr
);
    logic [15:0] hi_cnt, lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= psr_oe_ref_n ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
            lo_cnt <= (!psr_oe_ref_n && psr_sel_n) ?
                      ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1) : '0;
        end
    end

    // R3
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psr_dq_oe |-> (!psr_sel_n && !psr_wr_n));

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R4
    ack_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack) |-> $past(!psr_sel_n));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!psr_sel_n && $past(!psr_sel_n)) |-> $stable(psr_addr));

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(psr_oe_ref_n) && $past(psr_sel_n)) |-> (lo_cnt == 16'(PULSE_CYC)));

    // R5
    no_self_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt < 16'(SELF_CYC));

    // R6
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(psr_oe_ref_n) && psr_sel_n) |-> (hi_cnt >= 16'(RECOV_CYC)));

    // R6
    sel_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psr_sel_n) |-> $past(psr_oe_ref_n));
endmodule

bind psram_ctrl psram_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .RECOV_CYC (RECOV_CYC),
    .PULSE_CYC (PULSE_CYC),
    .SELF_CYC  (SELF_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_ack     (host_ack),
    .psr_sel_n    (psr_sel_n),
    .psr_wr_n     (psr_wr_n),
    .psr_oe_ref_n (psr_oe_ref_n),
    .psr_dq_oe    (psr_dq_oe),
    .psr_addr     (psr_addr)
);

// File: tb/psram_ctrl_tb_top.sv
module psram_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 19;
    localparam int DWD = 8;
    localparam int REF = 50;
    localparam int ACC = 3;
    localparam int PUL = 3;
    localparam int REC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0, host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DWD-1:0] host_wdata = '0;
    logic host_ack;
    logic [DWD-1:0] host_rdata;
    logic psr_sel_n, psr_wr_n, psr_oe_ref_n, psr_dq_oe;
    logic [AW-1:0] psr_addr;
    logic [DWD-1:0] psr_dq_out;
    logic [DWD-1:0] psr_dq_in = '0;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_ctrl #(
        .REF_CYC(REF), .ACC_CYC(ACC), .PULSE_CYC(PUL), .RECOV_CYC(REC), .SELF_CYC(20)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .psr_sel_n(psr_sel_n), .psr_wr_n(psr_wr_n), .psr_oe_ref_n(psr_oe_ref_n),
        .psr_addr(psr_addr), .psr_dq_out(psr_dq_out), .psr_dq_oe(psr_dq_oe),
        .psr_dq_in(psr_dq_in)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // memory array model and host scoreboard
    logic [DWD-1:0] arr [int];
    logic [DWD-1:0] sb  [int];

    // behavioural reference: 0 idle,1 setup,2 active,3 ack,4 refresh,5 recovery
    int m_st = 0, m_cnt = 0, m_t = 0, m_rf = 0, rf_seen = 0;
    bit m_due = 0, m_wr = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DWD-1:0] m_wd = '0, m_rd = '0;
    bit prev_oe = 1'b1;

    always @(posedge clk) begin
        int ns;
        bit nd;
        if (rst_n) begin
            ns = m_st; nd = m_due;
            case (m_st)
                0: if (m_due) begin ns = 4; m_cnt = PUL-1; nd = 0; m_rf++; end
                   else if (host_req) begin ns = 1; m_addr = host_addr; m_wd = host_wdata; m_wr = host_wr; end
                1: begin ns = 2; m_cnt = ACC-1; end
                2: if (m_cnt == 0) begin ns = 3; if (!m_wr) m_rd = psr_dq_in; end else m_cnt--;
                3: begin ns = 5; m_cnt = REC-1; end
                4: if (m_cnt == 0) begin ns = 5; m_cnt = REC-1; end else m_cnt--;
                default: if (m_cnt == 0) ns = 0; else m_cnt--;
            endcase
            m_t++;
            if (m_t % REF == 0) nd = 1;
            m_st = ns; m_due = nd;
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            chk(psr_sel_n == (m_st != 2), "R2 sel", psr_sel_n, m_st != 2);
            if (m_st == 2) begin
                chk(psr_addr == m_addr, "R2 addr", psr_addr, m_addr);
                chk(psr_wr_n == !m_wr, "R3 wr", psr_wr_n, !m_wr);
                if (m_wr) chk(psr_dq_out == m_wd, "R3 dq_out", psr_dq_out, m_wd);
            end
            chk(psr_dq_oe == (m_st == 2 && m_wr), "R3 dq_oe", psr_dq_oe, m_st == 2 && m_wr);
            chk(psr_oe_ref_n == !((m_st == 2 && !m_wr) || m_st == 4), "R5 oe_ref",
                psr_oe_ref_n, !((m_st == 2 && !m_wr) || m_st == 4));
            chk(host_ack == (m_st == 3), "R4 ack", host_ack, m_st == 3);
            if (m_st == 3 && !m_wr) chk(host_rdata == m_rd, "R4 rdata", host_rdata, m_rd);
            if (prev_oe && !psr_oe_ref_n && psr_sel_n) rf_seen++;
            prev_oe = psr_oe_ref_n;
            if (!psr_sel_n && !psr_wr_n && psr_dq_oe) arr[int'(psr_addr)] = psr_dq_out;
            if (!psr_sel_n && psr_wr_n && !psr_oe_ref_n)
                psr_dq_in = arr.exists(int'(psr_addr)) ? arr[int'(psr_addr)] : 8'hA5;
            else
                psr_dq_in = 8'h00;
        end
    end

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DWD-1:0] d);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        while (!host_ack) @(negedge clk);
        if (!wr) begin
            logic [DWD-1:0] e;
            e = sb.exists(int'(a)) ? sb[int'(a)] : 8'hA5;
            chk(host_rdata == e, "R4 readback", host_rdata, e);
        end else sb[int'(a)] = d;
        host_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        chk(rf_seen == m_rf, "R7 pulse count", rf_seen, m_rf);
        chk(rf_seen >= m_t/REF - 1, "R7 rate", rf_seen, m_t/REF - 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        idle(3);
        chk(psr_sel_n && psr_wr_n && psr_oe_ref_n && !psr_dq_oe && !host_ack,
            "R1 reset", {psr_sel_n, psr_wr_n, psr_oe_ref_n, psr_dq_oe, host_ack}, 5'b11100);
        rst_n = 1'b1;
        idle(2);
        chk(psr_sel_n && psr_oe_ref_n && !host_ack, "R1 idle",
            {psr_sel_n, psr_oe_ref_n, host_ack}, 3'b110);
        // corner addresses: zero, all ones, row only, column only
        access(1, 19'h00000, 8'h3C);
        access(1, 19'h7FFFF, 8'hC3);
        access(1, 19'h007FF, 8'h5A);
        access(1, 19'h7F800, 8'hA5 ^ 8'h0F);
        access(0, 19'h00000, 8'h00);
        access(0, 19'h7FFFF, 8'h00);
        access(0, 19'h007FF, 8'h00);
        access(0, 19'h7F800, 8'h00);
        access(0, 19'h12345, 8'h00);
        idle(4*REF);
        // R8: request lands while a refresh is already owed
        while (!(m_st == 0 && m_due && (m_t % REF) == 0)) @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_addr = 19'h7FFFF;
        @(negedge clk);
        chk(!psr_oe_ref_n && psr_sel_n, "R8 refresh first", {psr_sel_n, psr_oe_ref_n}, 2'b10);
        access(0, 19'h7FFFF, 8'h00);
        // R8: refresh falls due mid-access
        while (!(m_st == 0 && !m_due && (m_t % REF) == REF-3)) @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_addr = 19'h00400; host_wdata = 8'h77;
        while (!host_ack) @(negedge clk);
        sb[int'(19'h00400)] = 8'h77;
        host_req = 1'b0;
        repeat (REC + 2) @(negedge clk);
        chk(!psr_oe_ref_n && psr_sel_n, "R8 deferred refresh", {psr_sel_n, psr_oe_ref_n}, 2'b10);
        access(0, 19'h00400, 8'h00);
        idle(3*REF);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R7 watchdog", 0, 1);
        finish_run();
    end
endmodule